// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block moves one DMA transfer unit, 8 or 16 bits wide, from a source address to a destination address. It first reads the unit through a simple bus master port and then writes it. Each side has its own data bus width, 8 or 16 bits, its own wait-state count and its own ready enable. The sequencer turns the unit into one or two bus cycles ("beats") per side, according to that side's width and the low bit of its address. It keeps the read data in an internal holding register until the last write beat has finished.

A channel controller loads the addresses and the per-side settings, then pulses `start_i` while the block is idle. The block copies every setting at that moment and ignores its inputs for the rest of the unit. It raises `busy_o` while it works and gives a one-cycle `done_o` pulse when the unit is finished. The bus port has no address phase and no data phase: `bus_req_o` stays high for the whole beat. The address, write enable, byte enables and write data are held steady until the beat completes.

Byte lanes are fixed as follows. On a 16-bit side, a byte at an even address uses lane [7:0] and a byte at an odd address uses lane [15:8]. On an 8-bit side, every byte uses lane [7:0].

Top module: `dma_unit_seq`

## Requirements
- R1: A `start_i` pulse is taken only when `busy_o` is low. At that edge the block copies the addresses, widths, wait counts, unit size and ready enables. A `start_i` pulse or an input change while busy has no effect on the beats or on `done_o`.
- R2: All read beats come before the first write beat. `done_o` is high for exactly one cycle: the cycle right after the edge where the last write beat completes. `busy_o` is low in that cycle.
- R3: A beat on a side with wait count W keeps `bus_req_o` high for at least W+1 clock cycles. With ready disabled, it lasts exactly W+1 cycles.
- R4: If ready is enabled for a side (enable bit = 1), a beat on that side does not complete until `bus_rdy_i` is sampled high, and its address and direction stay fixed while it stalls. If ready is disabled, `bus_rdy_i` has no effect.
- R5: A 16-bit unit at an even address on a 16-bit side (width bit = 1) takes a single beat at that address, with `bus_be_o` = 2'b11 and the whole word on the data lanes.
- R6: A 16-bit unit at an odd address A on a 16-bit side takes two beats. The first is at A with `bus_be_o` = 2'b10 and carries the low data byte on lane [15:8]. The second is at A+1 with `bus_be_o` = 2'b01 and carries the high data byte on lane [7:0].
- R7: A 16-bit unit on an 8-bit side (width bit = 0) takes two beats, A and then A+1, both with `bus_be_o` = 2'b01 and lane [7:0]. The low data byte goes first. Mixed widths combine as two reads and one write, or one read and two writes.
- R8: An 8-bit unit takes exactly one read beat and one write beat, whatever the width or alignment. It uses lane [15:8] with `bus_be_o` = 2'b10 only for an odd address on a 16-bit side; otherwise it uses lane [7:0] with `bus_be_o` = 2'b01.
- R9: The data written equals the data read, with bytes joined little-endian: the byte from the lower address is bit [7:0] of the unit. `bus_wdata_o` lanes that are not enabled are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one transfer unit (taken when idle) |
| unit16_i | input | 1 | Unit size: 0 = 8-bit, 1 = 16-bit |
| src_addr_i | input | ADDR_W | Source byte address |
| dst_addr_i | input | ADDR_W | Destination byte address |
| src_wide_i | input | 1 | Source bus width: 0 = 8-bit, 1 = 16-bit |
| dst_wide_i | input | 1 | Destination bus width: 0 = 8-bit, 1 = 16-bit |
| src_wait_i | input | WAIT_W | Wait states per source beat |
| dst_wait_i | input | WAIT_W | Wait states per destination beat |
| src_rdy_en_i | input | 1 | Source beats wait for ready |
| dst_rdy_en_i | input | 1 | Destination beats wait for ready |
| busy_o | output | 1 | A unit is in progress |
| done_o | output | 1 | One-cycle pulse after the last write beat |
| bus_req_o | output | 1 | Beat in progress |
| bus_we_o | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr_o | output | ADDR_W | Beat byte address |
| bus_be_o | output | 2 | Byte lane enables, bit 1 = lane [15:8] |
| bus_wdata_o | output | 16 | Write data lanes |
| bus_rdata_i | input | 16 | Read data lanes |
| bus_rdy_i | input | 1 | Ready from the addressed slave |

## Verification
The bench works through every width and alignment pairing and compares the full beat log (address, lane enables, direction, length, write data) with an expected log written for each case. It catches several kinds of error. An odd 16-bit access issued as one word would show a wrong byte enable or a missing second beat. A mistake in lane choice or byte order would put swapped or misplaced bytes on the write lanes. An 8-bit side handled like a 16-bit one would lose a beat. Separate cases stretch beats with wait states and with a stalled ready input, including ready held low while disabled, to catch a timer that ends early or a ready gate on the wrong side. A second start pulse with a changed destination, sent in the middle of a unit, catches settings that are not latched and a repeated or mistimed done pulse.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA transfer cycle sequencer.
// Assumes: at most two beats per phase, so one bit indexes the beat.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    // Per-beat lane plan for one side.
    typedef struct packed {
        logic       two_beats;  // phase needs a second beat
        logic       word;       // beat moves a full 16-bit word
        logic       lane_hi;    // byte beat sits on lane [15:8]
        logic [1:0] be;         // byte enables for this beat
    } beat_ctl_t;

    // Settings copied at start.
    typedef struct packed {
        logic unit16;
        logic src_wide;
        logic dst_wide;
        logic src_rdy_en;
        logic dst_rdy_en;
    } xfer_mode_t;

endpackage

// File: rtl/dma_beat_plan.sv
// Beat planner: for one side, picks the beat count, lane and byte enables
// from the unit size, the bus width and the address low bit.
// Assumes: beat_i is 0 or 1; beat 1 targets address + 1.
module dma_beat_plan
    import dma_seq_pkg::*;
(
    input  logic      unit16_i,
    input  logic      wide_i,
    input  logic      addr_lsb_i,
    input  logic      beat_i,
    output beat_ctl_t ctl_o
);

    logic word_ok;
    logic byte_lsb;

    // Decide the access shape for the current beat.
    always_comb begin
        word_ok         = unit16_i && wide_i && !addr_lsb_i;
        byte_lsb        = addr_lsb_i ^ beat_i;
        ctl_o.word      = word_ok;
        ctl_o.two_beats = unit16_i && !word_ok;
        ctl_o.lane_hi   = wide_i && byte_lsb && !word_ok;
        if (word_ok) begin
            ctl_o.be = 2'b11;
        end else if (wide_i && byte_lsb) begin
            ctl_o.be = 2'b10;
        end else begin
            ctl_o.be = 2'b01;
        end
    end

endmodule

// File: rtl/dma_wait_timer.sv
// Beat timer: counts wait states for the active beat and reports the cycle
// in which the beat completes, gated by ready when ready is enabled.
// Assumes: active_i stays high for the whole beat; the count restarts
// after each completion.
module dma_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              rdy_en_i,
    input  logic              rdy_i,
    output logic              fire_o
);

    logic [WAIT_W-1:0] cnt_q;
    logic              reached;

    // Completion when wait states are used up and ready allows it.
    always_comb begin
        reached = (cnt_q == wait_i);
        fire_o  = active_i && reached && (!rdy_en_i || rdy_i);
    end

    // Wait-state counter, cleared between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || fire_o) begin
            cnt_q <= '0;
        end else if (!reached) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dma_unit_seq.sv
// DMA transfer cycle sequencer: moves one 8- or 16-bit unit through a read
// phase and then a write phase. Each phase takes one or two beats,
// depending on the side's bus width and address alignment.
// Assumes: the slave returns read data on bus_rdata_i in the completing
// cycle; settings are copied at start and held for the unit.
module dma_unit_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              unit16_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic              src_wide_i,
    input  logic              dst_wide_i,
    input  logic [WAIT_W-1:0] src_wait_i,
    input  logic [WAIT_W-1:0] dst_wait_i,
    input  logic              src_rdy_en_i,
    input  logic              dst_rdy_en_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_be_o,
    output logic [15:0]       bus_wdata_o,
    input  logic [15:0]       bus_rdata_i,
    input  logic              bus_rdy_i
);

    localparam int NSIDE = 2;   // 0 = source, 1 = destination

    seq_state_t        state_q;
    logic              beat_q;
    logic              done_q;
    logic [15:0]       hold_q;
    xfer_mode_t        mode_q;
    logic [ADDR_W-1:0] addr_q [NSIDE];
    logic [WAIT_W-1:0] wait_q [NSIDE];
    logic              side_wide [NSIDE];
    beat_ctl_t         side_ctl  [NSIDE];

    beat_ctl_t         cur;
    logic              in_write;
    logic              active;
    logic              fire;
    logic              last_beat;
    logic [WAIT_W-1:0] cur_wait;
    logic              cur_rdy_en;
    logic [7:0]        rd_byte;
    logic [7:0]        wr_byte;

    // Width select per side from the latched mode.
    always_comb begin
        side_wide[0] = mode_q.src_wide;
        side_wide[1] = mode_q.dst_wide;
    end

    // One lane planner for each side.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_beat_plan u_plan (
            .unit16_i   (mode_q.unit16),
            .wide_i     (side_wide[s]),
            .addr_lsb_i (addr_q[s][0]),
            .beat_i     (beat_q),
            .ctl_o      (side_ctl[s])
        );
    end

    // Pick the controls of the side in use.
    always_comb begin
        in_write   = (state_q == ST_WRITE);
        active     = (state_q != ST_IDLE);
        cur        = in_write ? side_ctl[1] : side_ctl[0];
        cur_wait   = in_write ? wait_q[1] : wait_q[0];
        cur_rdy_en = in_write ? mode_q.dst_rdy_en : mode_q.src_rdy_en;
        last_beat  = !cur.two_beats || beat_q;
    end

    dma_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .wait_i   (cur_wait),
        .rdy_en_i (cur_rdy_en),
        .rdy_i    (bus_rdy_i),
        .fire_o   (fire)
    );

    // Drive the bus port from the current beat.
    always_comb begin
        rd_byte     = cur.lane_hi ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
        wr_byte     = beat_q ? hold_q[15:8] : hold_q[7:0];
        bus_req_o   = active;
        bus_we_o    = in_write;
        bus_addr_o  = (in_write ? addr_q[1] : addr_q[0]) + ADDR_W'(beat_q);
        bus_be_o    = active ? cur.be : 2'b00;
        bus_wdata_o = '0;
        if (in_write) begin
            if (cur.word) begin
                bus_wdata_o = hold_q;
            end else if (cur.lane_hi) begin
                bus_wdata_o = {wr_byte, 8'h00};
            end else begin
                bus_wdata_o = {8'h00, wr_byte};
            end
        end
        busy_o = active;
        done_o = done_q;
    end

    // Phase and beat sequencing with start capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= 1'b0;
            done_q  <= 1'b0;
            mode_q  <= '0;
            for (int s = 0; s < NSIDE; s++) begin
                addr_q[s] <= '0;
                wait_q[s] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    state_q   <= ST_READ;
                    beat_q    <= 1'b0;
                    mode_q    <= '{unit16: unit16_i, src_wide: src_wide_i,
                                   dst_wide: dst_wide_i, src_rdy_en: src_rdy_en_i,
                                   dst_rdy_en: dst_rdy_en_i};
                    addr_q[0] <= src_addr_i;
                    addr_q[1] <= dst_addr_i;
                    wait_q[0] <= src_wait_i;
                    wait_q[1] <= dst_wait_i;
                end
            end else if (fire) begin
                if (!last_beat) begin
                    beat_q <= 1'b1;
                end else if (state_q == ST_READ) begin
                    state_q <= ST_WRITE;
                    beat_q  <= 1'b0;
                end else begin
                    state_q <= ST_IDLE;
                    beat_q  <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // Holding register: collects read bytes little-endian.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            hold_q <= '0;
        end else if (state_q == ST_READ && fire) begin
            if (cur.word) begin
                hold_q <= bus_rdata_i;
            end else if (beat_q) begin
                hold_q[15:8] <= rd_byte;
            end else begin
                hold_q[7:0] <= rd_byte;
            end
        end
    end

    // The write phase is entered only from the read phase.
    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && $past(state_q) != ST_WRITE) |-> $past(state_q) == ST_READ);

    // done_o lasts one cycle and follows a write beat.
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_we_o && bus_req_o));

    // Settings hold while a unit is in progress.
    assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mode_q) && $stable(addr_q[0]) && $stable(addr_q[1]));

    // A stalled beat keeps its address and direction.
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && cur_rdy_en && !bus_rdy_i) |=>
            bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

    // Split beats enable exactly one lane.
    assert_split_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !cur.word) |-> $countones(bus_be_o) == 1);

endmodule

// File: tb/dma_unit_seq_tb_top.sv
// Directed bench for the DMA transfer cycle sequencer: logs each beat at the
// port and compares it with a hand-written expected beat list.
module dma_unit_seq_tb_top;

    localparam int AW = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          unit16 = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic          src_wide = 1'b0;
    logic          dst_wide = 1'b0;
    logic [WW-1:0] src_wait = '0;
    logic [WW-1:0] dst_wait = '0;
    logic          src_rdy_en = 1'b0;
    logic          dst_rdy_en = 1'b0;
    logic          busy, done, req, we;
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic          rdy = 1'b1;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Beat log from the monitor.
    int          n_log;
    logic        log_we   [16];
    logic [7:0]  log_addr [16];
    logic [1:0]  log_be   [16];
    logic [15:0] log_wd   [16];
    int          log_len  [16];
    int          done_hits;
    int          done_cyc;
    int          last_req_cyc;
    logic        prev_req = 1'b0;
    logic        prev_we = 1'b0;
    logic [7:0]  prev_addr = '0;

    // Ready stimulus.
    int   stall = 0;
    logic hold_low = 1'b0;

    // Expected beat list.
    int          n_exp;
    logic        e_we   [16];
    logic [7:0]  e_addr [16];
    logic [1:0]  e_be   [16];
    logic [15:0] e_wd   [16];
    int          e_len  [16];

    always #2.5 clk = ~clk;

    dma_unit_seq #(.ADDR_W(AW), .WAIT_W(WW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .unit16_i     (unit16),
        .src_addr_i   (src_addr),
        .dst_addr_i   (dst_addr),
        .src_wide_i   (src_wide),
        .dst_wide_i   (dst_wide),
        .src_wait_i   (src_wait),
        .dst_wait_i   (dst_wait),
        .src_rdy_en_i (src_rdy_en),
        .dst_rdy_en_i (dst_rdy_en),
        .busy_o       (busy),
        .done_o       (done),
        .bus_req_o    (req),
        .bus_we_o     (we),
        .bus_addr_o   (addr),
        .bus_be_o     (be),
        .bus_wdata_o  (wdata),
        .bus_rdata_i  (rdata),
        .bus_rdy_i    (rdy)
    );

    function automatic logic [7:0] mb(input logic [7:0] a);
        return a * 8'd3 + 8'h17;
    endfunction

    // Source memory model; width follows the source width setting.
    always_comb begin
        if (src_wide) rdata = {mb({addr[7:1], 1'b1}), mb({addr[7:1], 1'b0})};
        else          rdata = {8'h00, mb(addr)};
    end

    // Monitor: beat log, done tracking and ready drive, away from the edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (req) begin
            if (!prev_req || addr != prev_addr || we != prev_we) begin
                log_we[n_log]   = we;
                log_addr[n_log] = addr;
                log_be[n_log]   = be;
                log_wd[n_log]   = wdata;
                log_len[n_log]  = 1;
                n_log = n_log + 1;
            end else begin
                log_len[n_log-1] = log_len[n_log-1] + 1;
            end
            last_req_cyc = cyc;
        end
        if (done) begin
            done_hits = done_hits + 1;
            done_cyc  = cyc;
        end
        prev_req  = req;
        prev_we   = we;
        prev_addr = addr;
        rdy = !hold_low && (stall == 0);
        if (req && stall > 0) stall = stall - 1;
    end

    // Watchdog.
    initial begin
        #(5 * 100000);
        failures = failures + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic exp_beat(input logic w, input logic [7:0] a, input logic [1:0] b,
                            input logic [15:0] d, input int len);
        e_we[n_exp] = w; e_addr[n_exp] = a; e_be[n_exp] = b;
        e_wd[n_exp] = d; e_len[n_exp] = len;
        n_exp = n_exp + 1;
    endtask

    // Run one unit; optionally pulse start again with a new destination mid-run.
    task automatic run(input bit sz, input bit sw, input bit dw,
                       input logic [7:0] sa, input logic [7:0] da,
                       input int swt, input int dwt, input bit sre, input bit dre,
                       input int stl, input bit hlow, input bit poke);
        @(negedge clk);
        n_log = 0; done_hits = 0; done_cyc = -1; last_req_cyc = -1; n_exp = 0;
        unit16 = sz; src_wide = sw; dst_wide = dw; src_addr = sa; dst_addr = da;
        src_wait = WW'(swt); dst_wait = WW'(dwt); src_rdy_en = sre; dst_rdy_en = dre;
        stall = stl; hold_low = hlow; rdy = !hlow && (stl == 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            dst_addr = 8'h90; src_addr = 8'h44; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 200 && done_hits == 0; i++) @(negedge clk);
        for (int i = 0; i < 4; i++) @(negedge clk);
        hold_low = 1'b0;
    endtask

    task automatic compare(input string tag);
        check(n_log == n_exp, tag, "beat count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            check(log_we[i] == e_we[i] && log_addr[i] == e_addr[i] && log_be[i] == e_be[i],
                  tag, $sformatf("beat %0d we/addr/be", i),
                  {log_we[i], log_addr[i], log_be[i]}, {e_we[i], e_addr[i], e_be[i]});
            if (e_we[i])
                check(log_wd[i] == e_wd[i], tag, $sformatf("beat %0d wdata", i),
                      log_wd[i], e_wd[i]);
            check(log_len[i] == e_len[i], tag, $sformatf("beat %0d length", i),
                  log_len[i], e_len[i]);
        end
        check(done_hits == 1, "R2", {tag, " done pulse count"}, done_hits, 1);
        check(done_cyc == last_req_cyc + 1, "R2", {tag, " done timing"},
              done_cyc, last_req_cyc + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !done && !req && be == 2'b00, "R1", "reset idle",
              {busy, done, req, be}, 0);
    endtask

    task automatic t_word_aligned();   // R5 R9
        run(1, 1, 1, 8'h20, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h20, 2'b11, 16'h0, 1);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h21), mb(8'h20)}, 1);
        compare("R5");
    endtask

    task automatic t_src_odd();        // R6 R9
        run(1, 1, 1, 8'h31, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h31, 2'b10, 16'h0, 1);
        exp_beat(0, 8'h32, 2'b01, 16'h0, 1);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h32), mb(8'h31)}, 1);
        compare("R6");
    endtask

    task automatic t_dst_odd();        // R6 R9
        run(1, 1, 1, 8'h20, 8'h85, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h20, 2'b11, 16'h0, 1);
        exp_beat(1, 8'h85, 2'b10, {mb(8'h20), 8'h00}, 1);
        exp_beat(1, 8'h86, 2'b01, {8'h00, mb(8'h21)}, 1);
        compare("R6");
    endtask

    task automatic t_both_narrow();    // R7
        run(1, 0, 0, 8'h31, 8'h85, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h31, 2'b01, 16'h0, 1);
        exp_beat(0, 8'h32, 2'b01, 16'h0, 1);
        exp_beat(1, 8'h85, 2'b01, {8'h00, mb(8'h31)}, 1);
        exp_beat(1, 8'h86, 2'b01, {8'h00, mb(8'h32)}, 1);
        compare("R7");
    endtask

    task automatic t_mixed();          // R7 R9
        run(1, 0, 1, 8'h20, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h20, 2'b01, 16'h0, 1);
        exp_beat(0, 8'h21, 2'b01, 16'h0, 1);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h21), mb(8'h20)}, 1);
        compare("R7");
        run(1, 1, 0, 8'h20, 8'h85, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h20, 2'b11, 16'h0, 1);
        exp_beat(1, 8'h85, 2'b01, {8'h00, mb(8'h20)}, 1);
        exp_beat(1, 8'h86, 2'b01, {8'h00, mb(8'h21)}, 1);
        compare("R9");
    endtask

    task automatic t_byte_unit();      // R8
        run(0, 1, 1, 8'h31, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h31, 2'b10, 16'h0, 1);
        exp_beat(1, 8'h80, 2'b01, {8'h00, mb(8'h31)}, 1);
        compare("R8");
        run(0, 0, 1, 8'h31, 8'h85, 0, 0, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h31, 2'b01, 16'h0, 1);
        exp_beat(1, 8'h85, 2'b10, {mb(8'h31), 8'h00}, 1);
        compare("R8");
    endtask

    task automatic t_waits();          // R3
        run(1, 0, 1, 8'h20, 8'h80, 3, 2, 0, 0, 0, 0, 0);
        exp_beat(0, 8'h20, 2'b01, 16'h0, 4);
        exp_beat(0, 8'h21, 2'b01, 16'h0, 4);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h21), mb(8'h20)}, 3);
        compare("R3");
    endtask

    task automatic t_ready();          // R4
        run(0, 1, 1, 8'h20, 8'h80, 0, 0, 1, 0, 3, 0, 0);
        exp_beat(0, 8'h20, 2'b01, 16'h0, 4);
        exp_beat(1, 8'h80, 2'b01, {8'h00, mb(8'h20)}, 1);
        compare("R4");
        run(0, 1, 1, 8'h20, 8'h80, 2, 0, 1, 0, 1, 0, 0);
        exp_beat(0, 8'h20, 2'b01, 16'h0, 3);
        exp_beat(1, 8'h80, 2'b01, {8'h00, mb(8'h20)}, 1);
        compare("R4");
        run(1, 1, 1, 8'h20, 8'h80, 0, 1, 0, 0, 0, 1, 0);
        exp_beat(0, 8'h20, 2'b11, 16'h0, 1);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h21), mb(8'h20)}, 2);
        compare("R4");
    endtask

    task automatic t_busy_start();     // R1
        run(1, 1, 1, 8'h20, 8'h80, 3, 3, 0, 0, 0, 0, 1);
        exp_beat(0, 8'h20, 2'b11, 16'h0, 4);
        exp_beat(1, 8'h80, 2'b11, {mb(8'h21), mb(8'h20)}, 4);
        compare("R1");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_aligned();
        t_src_odd();
        t_dst_odd();
        t_both_narrow();
        t_mixed();
        t_byte_unit();
        t_waits();
        t_ready();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule